// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits between a serial-bus front end and a byte-wide non-volatile array. The front end tells it when a word address has been received, when each data byte has arrived, and when the bus has seen a stop. The block gathers the data bytes of one page into a local buffer. Each byte slot has its own valid flag, so a partial page only touches the bytes that were actually sent.

When a stop closes a write that carried at least one data byte, the block walks the buffer. It writes every valid slot into a behavioural array through an internal write port, then clears the buffer. After that it holds a busy flag for a programmable number of clock ticks, which models the self-timed programming time. While busy is high, every strobe from the front end is ignored, so the front end can withhold the address acknowledge and let the master poll for completion.

A write-protect input is sampled at the first data byte of each transaction. A protected transaction keeps nothing and starts no cycle. The array has an asynchronous read port and comes out of reset erased, with every byte at `FF`.

Top module: `pgw_engine`

## Requirements
- R1: After reset, busy_o is low and every array byte reads `FF`.
- R2: A data byte is stored at the current in-page offset and the offset then advances by one. After the commit, exactly the bytes sent in the transaction hold their new values, and all other bytes of the page keep their old contents.
- R3: Only the low log2(PAGE_BYTES) address bits advance; the upper bits (the page number) stay fixed. After offset PAGE_BYTES-1 the next byte goes to offset 0 of the same page.
- R4: When more than PAGE_BYTES bytes are sent in one transaction, a later byte replaces the earlier byte at the same offset, and only the last value per offset is committed.
- R5: A stop starts a write cycle only if at least one data byte followed the word address. A word address followed directly by a stop leaves busy_o low and changes no byte.
- R6: busy_o rises in the cycle after the clock edge that samples the stop and stays high for exactly PAGE_BYTES + WR_TICKS cycles. It then returns low and stays low until another committing stop.
- R7: While busy_o is high, address loads, data strobes and stops have no effect on the array contents, on the length of the busy period, or on anything after it.
- R8: wp_i is sampled once, at the first data byte after a word address. If it is high then, the transaction writes nothing and starts no cycle. A change of wp_i after the first byte has no effect on that transaction.
- R9: The buffer is empty after each commit. A following transaction commits only its own bytes, even when it targets a different page.
- R10: Data strobes and stops that arrive while no transaction is open (no word address since the last stop) are ignored.
- R11: A new word address during an open transaction discards the bytes buffered so far and restarts at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load_i | input | 1 | One-cycle strobe: a word address has been received |
| addr_i | input | ADDR_W | Word address (page number and in-page offset) qualified by addr_load_i |
| data_strobe_i | input | 1 | One-cycle strobe: a data byte has been received |
| data_i | input | 8 | Data byte qualified by data_strobe_i |
| stop_i | input | 1 | One-cycle strobe: a stop was seen on the bus |
| wp_i | input | 1 | Write protect, high blocks writes |
| busy_o | output | 1 | High while the commit and the timed write cycle run |
| rd_addr_i | input | ADDR_W | Asynchronous read address into the array |
| rd_data_o | output | 8 | Array byte at rd_addr_i |

## Verification
Strobes are driven for one cycle at a falling edge, so the design samples each one at the next rising edge. busy_o is a registered state decode, so it is first high at the falling edge that ends the stop pulse. From there, a falling-edge counter must see it high for exactly PAGE_BYTES + WR_TICKS samples. Array contents are final by the first falling edge at which busy_o is low again, so every read-back check waits for that edge and then samples the asynchronous read port 1 ns after setting the address. Negative cases (dummy writes, protected or orphan stops) watch busy_o for several cycles after the stop and then read the targeted bytes.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // standby, waiting for a word address
        ST_FILL = 2'd1,   // transaction open, collecting data bytes
        ST_PROG = 2'd2,   // scanning the buffer into the array
        ST_WAIT = 2'd3    // timed programming interval
    } seq_state_e;

endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [OFF_W-1:0]  wr_off_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);

    typedef struct packed {
        logic [PAGE_BYTES-1:0][DATA_W-1:0] data;
        logic [PAGE_BYTES-1:0]             valid;
    } buf_t;

    buf_t buf_d, buf_q;

    // Per-slot next value: clearing drops the flags, a write sets one slot.
    // A write in the same cycle as a clear survives the clear.
    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        always_comb begin
            buf_d.data[s]  = buf_q.data[s];
            buf_d.valid[s] = buf_q.valid[s] & ~clr_i;
            if (we_i && (wr_off_i == OFF_W'(s))) begin
                buf_d.data[s]  = wr_data_i;
                buf_d.valid[s] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign rd_valid_o = buf_q.valid[rd_off_i];
    assign rd_data_o  = buf_q.data[rd_off_i];

endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] cell_q [DEPTH];

    // Behavioural store: comes out of reset in the erased state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= '1;
            end
        end else if (we_i) begin
            cell_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cell_q[raddr_i];

endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
    import pgw_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32,
    parameter int WR_TICKS   = 40,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFF_W,
    localparam int CNT_W     = $clog2(WR_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              strobe_i,
    input  logic              stop_i,
    input  logic              wp_i,
    input  logic              slot_valid_i,
    output logic              buf_we_o,
    output logic              buf_clr_o,
    output logic [OFF_W-1:0]  buf_off_o,
    output logic [OFF_W-1:0]  scan_off_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              busy_o
);

    localparam logic [OFF_W-1:0] LAST_OFF  = OFF_W'(PAGE_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(WR_TICKS - 1);

    typedef struct packed {
        seq_state_e         state;
        logic [PAGE_W-1:0]  page;
        logic [OFF_W-1:0]   off;
        logic [OFF_W-1:0]   scan;
        logic [CNT_W-1:0]   cnt;
        logic               seen;
        logic               prot;
    } seq_t;

    seq_t seq_d, seq_q;

    logic keep_byte;

    always_comb begin
        seq_d     = seq_q;
        buf_we_o  = 1'b0;
        buf_clr_o = 1'b0;
        mem_we_o  = 1'b0;
        keep_byte = 1'b0;

        unique case (seq_q.state)
            ST_IDLE: begin
                if (load_i) begin
                    seq_d.state = ST_FILL;
                    seq_d.page  = load_addr_i[ADDR_W-1:OFF_W];
                    seq_d.off   = load_addr_i[OFF_W-1:0];
                    seq_d.seen  = 1'b0;
                    seq_d.prot  = 1'b0;
                    buf_clr_o   = 1'b1;
                end
            end

            ST_FILL: begin
                if (load_i) begin
                    // repeated address: restart the page from scratch
                    seq_d.page = load_addr_i[ADDR_W-1:OFF_W];
                    seq_d.off  = load_addr_i[OFF_W-1:0];
                    seq_d.seen = 1'b0;
                    seq_d.prot = 1'b0;
                    buf_clr_o  = 1'b1;
                end else if (stop_i) begin
                    if (seq_q.seen && !seq_q.prot) begin
                        seq_d.state = ST_PROG;
                        seq_d.scan  = '0;
                    end else begin
                        seq_d.state = ST_IDLE;
                        buf_clr_o   = 1'b1;
                    end
                end else if (strobe_i) begin
                    // protection level is latched at the first data byte only
                    keep_byte  = seq_q.seen ? !seq_q.prot : !wp_i;
                    if (!seq_q.seen) begin
                        seq_d.prot = wp_i;
                    end
                    seq_d.seen = 1'b1;
                    buf_we_o   = keep_byte;
                    seq_d.off  = seq_q.off + 1'b1;
                end
            end

            ST_PROG: begin
                mem_we_o = slot_valid_i;
                if (seq_q.scan == LAST_OFF) begin
                    seq_d.state = ST_WAIT;
                    seq_d.cnt   = '0;
                    buf_clr_o   = 1'b1;
                end else begin
                    seq_d.scan = seq_q.scan + 1'b1;
                end
            end

            ST_WAIT: begin
                if (seq_q.cnt == LAST_TICK) begin
                    seq_d.state = ST_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end

            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign buf_off_o  = seq_q.off;
    assign scan_off_o = seq_q.scan;
    assign mem_addr_o = {seq_q.page, seq_q.scan};
    assign busy_o     = (seq_q.state == ST_PROG) || (seq_q.state == ST_WAIT);

endmodule

// File: rtl/pgw_engine.sv
module pgw_engine #(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32,
    parameter int WR_TICKS   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data_strobe_i,
    input  logic [7:0]        data_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              busy_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);

    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic              buf_we;
    logic              buf_clr;
    logic [OFF_W-1:0]  buf_off;
    logic [OFF_W-1:0]  scan_off;
    logic              slot_valid;
    logic [7:0]        slot_data;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;

    pgw_seq #(
        .ADDR_W    (ADDR_W),
        .PAGE_BYTES(PAGE_BYTES),
        .WR_TICKS  (WR_TICKS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (addr_load_i),
        .load_addr_i (addr_i),
        .strobe_i    (data_strobe_i),
        .stop_i      (stop_i),
        .wp_i        (wp_i),
        .slot_valid_i(slot_valid),
        .buf_we_o    (buf_we),
        .buf_clr_o   (buf_clr),
        .buf_off_o   (buf_off),
        .scan_off_o  (scan_off),
        .mem_we_o    (arr_we),
        .mem_addr_o  (arr_addr),
        .busy_o      (busy_o)
    );

    pgw_page_buf #(
        .PAGE_BYTES(PAGE_BYTES),
        .DATA_W    (8)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .we_i      (buf_we),
        .wr_off_i  (buf_off),
        .wr_data_i (data_i),
        .rd_off_i  (scan_off),
        .rd_valid_o(slot_valid),
        .rd_data_o (slot_data)
    );

    pgw_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(8)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (arr_we),
        .waddr_i(arr_addr),
        .wdata_i(slot_data),
        .raddr_i(rd_addr_i),
        .rdata_o(rd_data_o)
    );

endmodule

// File: rtl/pgw_engine_checker.sv
module pgw_engine_checker #(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32,
    parameter int WR_TICKS   = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_load_i,
    input logic              data_strobe_i,
    input logic              stop_i,
    input logic              wp_i,
    input logic              busy_o,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam logic [31:0] BUSY_LEN = 32'(PAGE_BYTES + WR_TICKS);

    logic [31:0] busy_len_q;
    logic        open_q;
    logic        seen_q;
    logic        first_wp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len_q <= '0;
            open_q     <= 1'b0;
            seen_q     <= 1'b0;
            first_wp_q <= 1'b0;
        end else begin
            busy_len_q <= busy_o ? busy_len_q + 32'd1 : 32'd0;
            if (!busy_o) begin
                if (addr_load_i) begin
                    open_q     <= 1'b1;
                    seen_q     <= 1'b0;
                    first_wp_q <= 1'b0;
                end else if (stop_i) begin
                    open_q <= 1'b0;
                end else if (data_strobe_i && open_q && !seen_q) begin
                    seen_q     <= 1'b1;
                    first_wp_q <= wp_i;
                end
            end
        end
    end

    // R7: the array is only written inside a busy period
    assert_write_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy_o);

    // R3: consecutive commit writes stay in one page
    assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
        (arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W])));

    // R4: each offset is committed at most once, in rising order
    assert_offset_rising_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
        (arr_addr[OFF_W-1:0] > $past(arr_addr[OFF_W-1:0])));

    // R5: a busy period only ever starts right after a stop
    assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    // R6: busy period length
    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_len_q == BUSY_LEN));

    // R8: no busy period for a transaction protected at its first byte
    assert_protected_no_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !first_wp_q);

endmodule

bind pgw_engine pgw_engine_checker #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES),
    .WR_TICKS  (WR_TICKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_load_i  (addr_load_i),
    .data_strobe_i(data_strobe_i),
    .stop_i       (stop_i),
    .wp_i         (wp_i),
    .busy_o       (busy_o),
    .arr_we       (arr_we),
    .arr_addr     (arr_addr)
);

// File: tb/pgw_engine_bench.sv
`timescale 1ns/1ps
module pgw_engine_bench;

    localparam int ADDR_W     = 10;
    localparam int PAGE_BYTES = 32;
    localparam int WR_TICKS   = 40;
    localparam int BUSY_LEN   = PAGE_BYTES + WR_TICKS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              addr_load_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              data_strobe_i = 1'b0;
    logic [7:0]        data_i = '0;
    logic              stop_i = 1'b0;
    logic              wp_i = 1'b0;
    logic              busy_o;
    logic [ADDR_W-1:0] rd_addr_i = '0;
    logic [7:0]        rd_data_o;

    int checks = 0;
    int errors = 0;
    int busy_seen = 0;

    always #2.5 clk = ~clk;

    pgw_engine #(
        .ADDR_W    (ADDR_W),
        .PAGE_BYTES(PAGE_BYTES),
        .WR_TICKS  (WR_TICKS)
    ) u_pgw_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_load_i  (addr_load_i),
        .addr_i       (addr_i),
        .data_strobe_i(data_strobe_i),
        .data_i       (data_i),
        .stop_i       (stop_i),
        .wp_i         (wp_i),
        .busy_o       (busy_o),
        .rd_addr_i    (rd_addr_i),
        .rd_data_o    (rd_data_o)
    );

    always @(negedge clk) begin
        if (busy_o === 1'b1) busy_seen++;
    end

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic peek(input int a, output int v);
        rd_addr_i = ADDR_W'(a);
        #1;
        v = int'(rd_data_o);
    endtask

    task automatic check_mem(input string tag, input int a, input int exp);
        int v;
        peek(a, v);
        check_val(tag, v, exp);
    endtask

    task automatic load(input int a);
        @(negedge clk);
        addr_i = ADDR_W'(a);
        addr_load_i = 1'b1;
        @(negedge clk);
        addr_load_i = 1'b0;
    endtask

    task automatic send_byte(input int d);
        @(negedge clk);
        data_i = 8'(d);
        data_strobe_i = 1'b1;
        @(negedge clk);
        data_strobe_i = 1'b0;
    endtask

    task automatic send_stop();
        @(negedge clk);
        busy_seen = 0;
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o !== 1'b0) @(negedge clk);
    endtask

    task automatic t_reset();
        check_val("R1 busy after reset", int'(busy_o), 0);
        check_mem("R1 erased low byte", 0, 8'hFF);
        check_mem("R1 erased top byte", 1023, 8'hFF);
    endtask

    task automatic t_partial();
        load('h045);
        send_byte('hA0); send_byte('hA1); send_byte('hA2);
        send_stop();
        wait_idle();
        check_val("R6 busy length", busy_seen, BUSY_LEN);
        repeat (4) @(negedge clk);
        check_val("R6 busy stays low", int'(busy_o), 0);
        check_mem("R2 byte 0", 'h045, 'hA0);
        check_mem("R2 byte 1", 'h046, 'hA1);
        check_mem("R2 byte 2", 'h047, 'hA2);
        check_mem("R2 below untouched", 'h044, 'hFF);
        check_mem("R2 above untouched", 'h048, 'hFF);
    endtask

    task automatic t_wrap();
        load('h07E);
        send_byte('h11); send_byte('h22); send_byte('h33);
        send_stop();
        wait_idle();
        check_mem("R3 offset 30", 'h07E, 'h11);
        check_mem("R3 offset 31", 'h07F, 'h22);
        check_mem("R3 wrapped to offset 0", 'h060, 'h33);
        check_mem("R3 next page untouched", 'h080, 'hFF);
    endtask

    task automatic t_overrun();
        load('h100);
        for (int i = 0; i < PAGE_BYTES + 2; i++) send_byte(i + 1);
        send_stop();
        wait_idle();
        check_mem("R4 offset 0 overwritten", 'h100, 33);
        check_mem("R4 offset 1 overwritten", 'h101, 34);
        check_mem("R4 offset 2 kept", 'h102, 3);
        check_mem("R4 offset 31 kept", 'h11F, 32);
    endtask

    task automatic t_dummy();
        load('h150);
        send_stop();
        repeat (5) @(negedge clk);
        check_val("R5 dummy write no busy", busy_seen, 0);
        check_mem("R5 dummy write no change", 'h150, 'hFF);
        // orphan strobe and stop with no open transaction
        send_byte('h5C);
        send_stop();
        repeat (5) @(negedge clk);
        check_val("R10 orphan stop no busy", busy_seen, 0);
        check_mem("R10 orphan byte ignored", 'h150, 'hFF);
    endtask

    task automatic t_busy_ignore();
        load('h200);
        send_byte('h5A);
        send_stop();
        repeat (3) @(negedge clk);
        load('h210);
        send_byte('h77);
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        wait_idle();
        check_val("R7 busy length unchanged", busy_seen, BUSY_LEN);
        repeat (6) @(negedge clk);
        check_val("R7 no queued cycle", int'(busy_o), 0);
        check_mem("R7 committed byte", 'h200, 'h5A);
        check_mem("R7 ignored byte", 'h210, 'hFF);
    endtask

    task automatic t_protect();
        wp_i = 1'b1;
        load('h300);
        send_byte('h99);
        wp_i = 1'b0;
        send_byte('h98);
        send_stop();
        repeat (5) @(negedge clk);
        check_val("R8 protected no busy", busy_seen, 0);
        check_mem("R8 protected byte 0", 'h300, 'hFF);
        check_mem("R8 protected byte 1", 'h301, 'hFF);
        load('h320);
        send_byte('h44);
        wp_i = 1'b1;
        send_byte('h45);
        send_stop();
        wp_i = 1'b0;
        wait_idle();
        check_val("R8 late protect busy", busy_seen, BUSY_LEN);
        check_mem("R8 late protect byte 0", 'h320, 'h44);
        check_mem("R8 late protect byte 1", 'h321, 'h45);
    endtask

    task automatic t_clear();
        load('h380);
        for (int i = 0; i < 4; i++) send_byte('hC0 + i);
        send_stop();
        wait_idle();
        load('h3A2);
        send_byte('hD0);
        send_stop();
        wait_idle();
        check_mem("R9 new byte", 'h3A2, 'hD0);
        check_mem("R9 stale slot 0", 'h3A0, 'hFF);
        check_mem("R9 stale slot 1", 'h3A1, 'hFF);
        check_mem("R9 stale slot 3", 'h3A3, 'hFF);
    endtask

    task automatic t_restart();
        load('h0C0);
        send_byte('hE1); send_byte('hE2);
        load('h0C8);
        send_byte('hE3);
        send_stop();
        wait_idle();
        check_mem("R11 discarded byte 0", 'h0C0, 'hFF);
        check_mem("R11 discarded byte 1", 'h0C1, 'hFF);
        check_mem("R11 restarted byte", 'h0C8, 'hE3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_partial();
        t_wrap();
        t_overrun();
        t_dummy();
        t_busy_ignore();
        t_protect();
        t_clear();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule